// File: doc/BRIEF.md
# Power-State Wakeup Event Controller

This block sits beside a single serial-port function and applies the side effects of the power state that a host programs. It also turns activity on external lines into a wake request. The host writes a power-management control/status word. That word holds a 2-bit power-state field, a wake-enable bit and a sticky wake-status bit. In the two sleep states the block switches off the serial-port clock enable, holds the interrupt output low and refuses memory/IO window accesses. Configuration accesses are always granted.

Four modem-status lines, the serial data input and two general-purpose pins are each passed through a two-flop synchronizer and then watched for wake conditions. Which sources count depends on the state:

- In deep sleep (D3), only the falling edge of the ring-indicator line counts.
- In doze (D2), any change on an unmasked modem line or on the serial input counts.
- The general-purpose pins count in every state, under a per-pin mode.

A detected event drives the active-low wake output low in the same cycle. It also latches the status bit, which keeps the output low until the host clears the bit. The block never changes the power state on its own.

A state machine tracks the power state with four states:

- `ST_RUN`: D0 or D1.
- `ST_DOZE`: D2 with the clock off.
- `ST_DOZE_RX`: D2 with the clock restarted by serial input activity.
- `ST_DEEP`: D3.

Its transitions are:

- T_ENTER_DOZE: a write of field 10 from a different field.
- T_ENTER_DEEP: a write of field 11 from a different field.
- T_RESUME: a write of field 00 or 01 from a different field.
- T_RX_RESTART: a serial-input event in `ST_DOZE`. It moves to `ST_DOZE_RX`.

A write that repeats the current field leaves the state as it is.

Top module: `pm_wake_ctrl`

## Requirements
- R1: The power-state field (csr bits [1:0]) changes only on a host write to the control/status word. It reads back exactly as written. Code 00 is D0, 01 is D1, 10 is D2 and 11 is D3. D0 and D1 are both treated as fully powered.
- R2: With field 10 or 11, the block forces off `irq_out` and `acc_grant` for window accesses (`acc_is_cfg`=0). It also drives `uart_clk_en` low, except in the clock-restarted doze state. In D0 and D1, `irq_out` follows `irq_in`, window accesses are granted and `uart_clk_en` is 1.
- R3: A configuration access (`acc_req`=1, `acc_is_cfg`=1) is granted in every power state.
- R4: The wake-status bit (csr bit 15) is set by a detected event only while the wake-enable bit (csr bit 8) is 1. `wake_n` is 0 exactly while enable is 1 and either the status bit is 1 or an event is being detected.
- R5: Writing 1 to csr bit 15 clears the status bit, and writing 0 leaves it unchanged. An event detected in the same cycle as the clear write wins, so the bit stays set.
- R6: `wake_n` goes low in the same cycle the synchronized event is detected, one cycle before the status bit reads back as 1. There is no filter delay.
- R7: In D3 the only serial-port wake is a 1-to-0 transition of the ring-indicator line (`modem_in[2]`). This source ignores the masks. Other modem lines and the serial input are ignored in D3.
- R8: In D2 a change on `modem_in[i]` wakes when mask bit `cfg[i]` is 0. A change on `sin` wakes when `cfg[4]` is 0. All configuration bits reset to 0, so every source is allowed after reset.
- R9: An unmasked `sin` change while in D2 sets `uart_clk_en` to 1 and keeps it there until the host writes a different power-state field.
- R10: General-purpose pin g uses mode bits `cfg[5+2g +: 2]`: 00 is disabled, 01 wakes on high, 10 wakes on low, 11 wakes on any change. These pins wake in every power state.
- R11: In D0 and D1, modem-line and serial-input activity never raises a wake.
- R12: During and after reset, csr readback is 0, the configuration is 0, `wake_n` is 1, `uart_clk_en` is 1 and the state is fully powered D0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr_en | input | 1 | Host write strobe for the control/status word |
| csr_wdata | input | 16 | Write data: [1:0] power state, [8] wake enable, [15] write-1-to-clear status |
| csr_rdata | output | 16 | Readback: [1:0] state, [8] enable, [15] status, other bits 0 |
| cfg_wr_en | input | 1 | Write strobe for the wake configuration word |
| cfg_wdata | input | 9 | [3:0] modem masks, [4] serial-input mask, [6:5] pin 0 mode, [8:7] pin 1 mode |
| modem_in | input | 4 | Asynchronous modem-status lines, [2] is ring indicator |
| sin | input | 1 | Asynchronous serial data input |
| gp_pin | input | 2 | Asynchronous general-purpose wake pins |
| irq_in | input | 1 | Interrupt request from the serial core |
| irq_out | output | 1 | Gated interrupt to the host |
| acc_req | input | 1 | Host access request |
| acc_is_cfg | input | 1 | 1 when the request is a configuration access |
| acc_grant | output | 1 | Access accepted |
| uart_clk_en | output | 1 | Serial-port clock enable |
| wake_n | output | 1 | Active-low wake request |

## Verification
The bench goes after these corner cases:

- **Ring indicator in D3.** A rising ring-indicator edge must not wake the function, and only the later fall does. A design that woke on either edge would latch status one vector too early.
- **Write-1-to-clear with a level source.** A clear written while a general-purpose pin still holds its level condition must leave the status set. A design that let the clear win would drop a live wake.
- **Enable off.** An event seen with the enable bit off must leave status 0. A design that latched it anyway would raise a stale wake as soon as the enable returns.
- **Same-cycle wake.** The bench polls cycle by cycle and requires `wake_n` to fall while status still reads 0, which catches a wake output that was only a registered copy of status.
- **Reset of the masks.** After a reset, a modem line that was masked before must wake again.
- **Clock restart.** Serial-input activity in D2 must turn the clock enable back on without reopening interrupts or window accesses.

// File: rtl/pmw_pkg.sv
package pmw_pkg;

    // Power-state field encodings
    localparam logic [1:0] PS_D0 = 2'b00;
    localparam logic [1:0] PS_D1 = 2'b01;
    localparam logic [1:0] PS_D2 = 2'b10;
    localparam logic [1:0] PS_D3 = 2'b11;

    // Control/status word bit positions
    localparam int CSR_W        = 16;
    localparam int CSR_EN_BIT   = 8;
    localparam int CSR_STAT_BIT = 15;

    typedef enum logic [1:0] {
        ST_RUN,      // D0 / D1, fully powered
        ST_DOZE,     // D2, clock off
        ST_DOZE_RX,  // D2, clock restarted by serial input
        ST_DEEP      // D3
    } pm_state_e;

    typedef enum logic [1:0] {
        GP_OFF  = 2'b00,
        GP_HIGH = 2'b01,
        GP_LOW  = 2'b10,
        GP_ANY  = 2'b11
    } gp_mode_e;

endpackage

// File: rtl/pmw_sync.sv
module pmw_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/pmw_wake_detect.sv
module pmw_wake_detect
    import pmw_pkg::*;
#(
    parameter int N_MODEM = 4,
    parameter int N_GP    = 2,
    parameter int RI_IDX  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_MODEM-1:0]  mdm_s,
    input  logic                sin_s,
    input  logic [N_GP-1:0]     gp_s,
    input  pm_state_e           state,
    input  logic [N_MODEM:0]    mask,
    input  logic [2*N_GP-1:0]   gp_mode,
    output logic                serial_evt,
    output logic                sin_evt,
    output logic                gp_evt
);

    logic [N_MODEM-1:0] mdm_q;
    logic               sin_q;
    logic [N_GP-1:0]    gp_q;
    logic [N_MODEM-1:0] mdm_chg;
    logic               ri_fall;
    logic [N_GP-1:0]    gp_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdm_q <= '0;
            sin_q <= 1'b0;
            gp_q  <= '0;
        end else begin
            mdm_q <= mdm_s;
            sin_q <= sin_s;
            gp_q  <= gp_s;
        end
    end

    assign mdm_chg = (mdm_s ^ mdm_q) & ~mask[N_MODEM-1:0];
    assign ri_fall = mdm_q[RI_IDX] & ~mdm_s[RI_IDX];

    always_comb begin
        serial_evt = 1'b0;
        sin_evt    = 1'b0;
        unique case (state)
            ST_DOZE, ST_DOZE_RX: begin
                sin_evt    = (sin_s ^ sin_q) & ~mask[N_MODEM];
                serial_evt = (|mdm_chg) | sin_evt;
            end
            ST_DEEP: serial_evt = ri_fall;
            ST_RUN:  serial_evt = 1'b0;
        endcase
    end

    for (genvar g = 0; g < N_GP; g++) begin : g_gp
        gp_mode_e mode_g;
        logic     hit_g;
        assign mode_g = gp_mode_e'(gp_mode[2*g +: 2]);
        always_comb begin
            unique case (mode_g)
                GP_OFF:  hit_g = 1'b0;
                GP_HIGH: hit_g = gp_s[g];
                GP_LOW:  hit_g = ~gp_s[g];
                GP_ANY:  hit_g = gp_s[g] ^ gp_q[g];
            endcase
        end
        assign gp_hit[g] = hit_g;
    end

    assign gp_evt = |gp_hit;

    // R11
    run_no_serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> !serial_evt);

    // R7
    deep_ri_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEEP && serial_evt) |-> (mdm_q[RI_IDX] && !mdm_s[RI_IDX]));

endmodule

// File: rtl/pmw_state_fsm.sv
module pmw_state_fsm
    import pmw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fld_load,
    input  logic [1:0] fld_val,
    input  logic       sin_evt,
    output pm_state_e  state,
    output logic       low_pwr,
    output logic       clk_en
);

    pm_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (fld_load) begin
            unique case (fld_val)
                PS_D2:        st_d = ST_DOZE;   // T_ENTER_DOZE
                PS_D3:        st_d = ST_DEEP;   // T_ENTER_DEEP
                PS_D0, PS_D1: st_d = ST_RUN;    // T_RESUME
            endcase
        end else if (st_q == ST_DOZE && sin_evt) begin
            st_d = ST_DOZE_RX;                  // T_RX_RESTART
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            ST_RUN:     begin low_pwr = 1'b0; clk_en = 1'b1; end
            ST_DOZE:    begin low_pwr = 1'b1; clk_en = 1'b0; end
            ST_DOZE_RX: begin low_pwr = 1'b1; clk_en = 1'b1; end
            ST_DEEP:    begin low_pwr = 1'b1; clk_en = 1'b0; end
        endcase
    end

    assign state = st_q;

    // R9
    rx_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DOZE && sin_evt && !fld_load) |=> (st_q == ST_DOZE_RX && clk_en));

endmodule

// File: rtl/pm_wake_ctrl.sv
module pm_wake_ctrl
    import pmw_pkg::*;
#(
    parameter int N_MODEM = 4,
    parameter int N_GP    = 2,
    parameter int RI_IDX  = 2,
    parameter int SYNC_N  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         csr_wr_en,
    input  logic [15:0]                  csr_wdata,
    output logic [15:0]                  csr_rdata,
    input  logic                         cfg_wr_en,
    input  logic [N_MODEM+2*N_GP:0]      cfg_wdata,
    input  logic [N_MODEM-1:0]           modem_in,
    input  logic                         sin,
    input  logic [N_GP-1:0]              gp_pin,
    input  logic                         irq_in,
    output logic                         irq_out,
    input  logic                         acc_req,
    input  logic                         acc_is_cfg,
    output logic                         acc_grant,
    output logic                         uart_clk_en,
    output logic                         wake_n
);

    localparam int MASK_W = N_MODEM + 1;
    localparam int CFG_W  = MASK_W + 2 * N_GP;
    localparam int SYN_W  = N_MODEM + 1 + N_GP;

    logic [1:0]         ps_field;
    logic               pme_en;
    logic               pme_stat;
    logic [CFG_W-1:0]   cfg_q;
    logic [SYN_W-1:0]   syn_q;
    logic [N_MODEM-1:0] mdm_s;
    logic               sin_s;
    logic [N_GP-1:0]    gp_s;
    logic               serial_evt, sin_evt, gp_evt, any_evt;
    logic               fld_load, low_pwr, fsm_clk_en;
    pm_state_e          state;

    pmw_sync #(.W(SYN_W), .STAGES(SYNC_N)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({gp_pin, sin, modem_in}),
        .q     (syn_q)
    );

    assign mdm_s = syn_q[N_MODEM-1:0];
    assign sin_s = syn_q[N_MODEM];
    assign gp_s  = syn_q[SYN_W-1 -: N_GP];

    pmw_wake_detect #(.N_MODEM(N_MODEM), .N_GP(N_GP), .RI_IDX(RI_IDX)) i_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .mdm_s      (mdm_s),
        .sin_s      (sin_s),
        .gp_s       (gp_s),
        .state      (state),
        .mask       (cfg_q[MASK_W-1:0]),
        .gp_mode    (cfg_q[CFG_W-1:MASK_W]),
        .serial_evt (serial_evt),
        .sin_evt    (sin_evt),
        .gp_evt     (gp_evt)
    );

    assign fld_load = csr_wr_en && (csr_wdata[1:0] != ps_field);

    pmw_state_fsm i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .fld_load (fld_load),
        .fld_val  (csr_wdata[1:0]),
        .sin_evt  (sin_evt),
        .state    (state),
        .low_pwr  (low_pwr),
        .clk_en   (fsm_clk_en)
    );

    assign any_evt = serial_evt | gp_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_field <= PS_D0;
            pme_en   <= 1'b0;
            pme_stat <= 1'b0;
            cfg_q    <= '0;
        end else begin
            if (csr_wr_en) begin
                ps_field <= csr_wdata[1:0];
                pme_en   <= csr_wdata[CSR_EN_BIT];
            end
            if (pme_en && any_evt)
                pme_stat <= 1'b1;
            else if (csr_wr_en && csr_wdata[CSR_STAT_BIT])
                pme_stat <= 1'b0;
            if (cfg_wr_en)
                cfg_q <= cfg_wdata;
        end
    end

    always_comb begin
        csr_rdata               = '0;
        csr_rdata[1:0]          = ps_field;
        csr_rdata[CSR_EN_BIT]   = pme_en;
        csr_rdata[CSR_STAT_BIT] = pme_stat;
    end

    assign irq_out     = irq_in & ~low_pwr;
    assign acc_grant   = acc_req & (acc_is_cfg | ~low_pwr);
    assign uart_clk_en = fsm_clk_en;
    assign wake_n      = ~(pme_en & (pme_stat | any_evt));

    // R1
    field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_wr_en |=> $stable(ps_field));

    // R2
    sleep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ps_field[1] |-> (!irq_out && !(acc_req && !acc_is_cfg && acc_grant)));

    // R2
    deep_clk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_field == PS_D3) |-> !uart_clk_en);

    // R3
    cfg_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_is_cfg) |-> acc_grant);

    // R4
    stat_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pme_stat) |-> $past(pme_en));

    // R5
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr_en && csr_wdata[CSR_STAT_BIT] && !(pme_en && any_evt)) |=> !pme_stat);

    // R5
    w0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr_en && !csr_wdata[CSR_STAT_BIT] && pme_stat) |=> pme_stat);

    // R6
    same_cycle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pme_en && any_evt) |-> !wake_n);

endmodule

// File: tb/test_pm_wake_ctrl.sv
module test_pm_wake_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr_en = 1'b0;
    logic [15:0] csr_wdata = '0;
    logic [15:0] csr_rdata;
    logic        cfg_wr_en = 1'b0;
    logic [8:0]  cfg_wdata = '0;
    logic [3:0]  modem_in = '0;
    logic        sin = 1'b1;
    logic [1:0]  gp_pin = '0;
    logic        irq_in = 1'b1;
    logic        irq_out;
    logic        acc_req = 1'b1;
    logic        acc_is_cfg = 1'b0;
    logic        acc_grant;
    logic        uart_clk_en;
    logic        wake_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pm_wake_ctrl i_pm_wake_ctrl (
        .clk(clk), .rst_n(rst_n),
        .csr_wr_en(csr_wr_en), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
        .modem_in(modem_in), .sin(sin), .gp_pin(gp_pin),
        .irq_in(irq_in), .irq_out(irq_out),
        .acc_req(acc_req), .acc_is_cfg(acc_is_cfg), .acc_grant(acc_grant),
        .uart_clk_en(uart_clk_en), .wake_n(wake_n)
    );

    // exp = {wake_n, uart_clk_en, irq_out, acc_grant, status, field[1:0]}
    typedef struct packed {
        logic [3:0]  mdm;
        logic        sn;
        logic [1:0]  gp;
        logic        cfg;
        logic        wr;
        logic [15:0] wd;
        logic        cw;
        logic [8:0]  cwd;
        logic [6:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        '{4'h0, 1'b1, 2'b00, 1'b0, 1'b0, 16'h0000, 1'b0, 9'h000, 7'b1111000, 4'd2},  // R2 D0 passes
        '{4'h1, 1'b1, 2'b00, 1'b0, 1'b1, 16'h0100, 1'b0, 9'h000, 7'b1111000, 4'd11}, // R11 modem in D0
        '{4'h1, 1'b1, 2'b00, 1'b0, 1'b1, 16'h0102, 1'b0, 9'h000, 7'b1000010, 4'd2},  // R2 enter D2
        '{4'h1, 1'b1, 2'b00, 1'b1, 1'b0, 16'h0000, 1'b0, 9'h000, 7'b1001010, 4'd3},  // R3 cfg in D2
        '{4'h3, 1'b1, 2'b00, 1'b0, 1'b0, 16'h0000, 1'b0, 9'h000, 7'b0000110, 4'd8},  // R8 dsr change
        '{4'h3, 1'b1, 2'b00, 1'b0, 1'b1, 16'h0102, 1'b0, 9'h000, 7'b0000110, 4'd5},  // R5 write 0 keeps
        '{4'h3, 1'b1, 2'b00, 1'b0, 1'b1, 16'h8102, 1'b0, 9'h000, 7'b1000010, 4'd5},  // R5 write 1 clears
        '{4'h3, 1'b0, 2'b00, 1'b0, 1'b0, 16'h0000, 1'b0, 9'h000, 7'b0100110, 4'd9},  // R9 sin restarts clk
        '{4'h3, 1'b0, 2'b00, 1'b0, 1'b1, 16'h8103, 1'b0, 9'h000, 7'b1000011, 4'd2},  // R2 enter D3
        '{4'h7, 1'b0, 2'b00, 1'b0, 1'b0, 16'h0000, 1'b0, 9'h000, 7'b1000011, 4'd7},  // R7 ri rise ignored
        '{4'h3, 1'b0, 2'b00, 1'b0, 1'b0, 16'h0000, 1'b0, 9'h000, 7'b0000111, 4'd7},  // R7 ri fall wakes
        '{4'h7, 1'b0, 2'b00, 1'b0, 1'b1, 16'h8003, 1'b0, 9'h000, 7'b1000011, 4'd4},  // R4 disable
        '{4'h3, 1'b0, 2'b00, 1'b0, 1'b0, 16'h0000, 1'b0, 9'h000, 7'b1000011, 4'd4},  // R4 no latch
        '{4'h3, 1'b0, 2'b00, 1'b0, 1'b1, 16'h0103, 1'b0, 9'h000, 7'b1000011, 4'd4},  // R4 re-enable
        '{4'h3, 1'b1, 2'b00, 1'b0, 1'b0, 16'h0000, 1'b0, 9'h000, 7'b1000011, 4'd7},  // R7 sin in D3
        '{4'h3, 1'b1, 2'b00, 1'b0, 1'b1, 16'h0101, 1'b0, 9'h000, 7'b1111001, 4'd1},  // R1 D1 powered
        '{4'h3, 1'b1, 2'b00, 1'b0, 1'b1, 16'h0100, 1'b1, 9'h020, 7'b1111000, 4'd10}, // R10 gp0 high mode
        '{4'h3, 1'b1, 2'b01, 1'b0, 1'b0, 16'h0000, 1'b0, 9'h000, 7'b0111100, 4'd10}, // R10 gp0 high
        '{4'h3, 1'b1, 2'b01, 1'b0, 1'b1, 16'h8100, 1'b0, 9'h000, 7'b0111100, 4'd5},  // R5 event wins
        '{4'h3, 1'b1, 2'b00, 1'b0, 1'b1, 16'h8100, 1'b0, 9'h000, 7'b1111000, 4'd5},  // R5 clear
        '{4'h3, 1'b1, 2'b00, 1'b0, 1'b1, 16'h0100, 1'b1, 9'h100, 7'b0111100, 4'd10}, // R10 gp1 low
        '{4'h3, 1'b1, 2'b10, 1'b0, 1'b1, 16'h8103, 1'b1, 9'h180, 7'b1000011, 4'd10}, // R10 gp1 any
        '{4'h3, 1'b1, 2'b00, 1'b0, 1'b0, 16'h0000, 1'b0, 9'h000, 7'b0000111, 4'd10}, // R10 gp in D3
        '{4'h3, 1'b1, 2'b00, 1'b0, 1'b1, 16'h8102, 1'b1, 9'h001, 7'b1000010, 4'd8},  // R8 mask cts
        '{4'h2, 1'b1, 2'b00, 1'b0, 1'b0, 16'h0000, 1'b0, 9'h000, 7'b1000010, 4'd8},  // R8 cts masked
        '{4'h0, 1'b1, 2'b00, 1'b0, 1'b0, 16'h0000, 1'b0, 9'h000, 7'b0000110, 4'd8},  // R8 dsr unmasked
        '{4'h0, 1'b1, 2'b00, 1'b0, 1'b1, 16'h0000, 1'b0, 9'h000, 7'b1111100, 4'd4},  // R4 wake needs en
        '{4'h0, 1'b1, 2'b00, 1'b0, 1'b1, 16'h8000, 1'b0, 9'h000, 7'b1111000, 4'd5}   // R5 final clear
    };

    function automatic logic [6:0] observe();
        return {wake_n, uart_clk_en, irq_out, acc_grant, csr_rdata[15], csr_rdata[1:0]};
    endfunction

    task automatic check(input int req, input logic [15:0] act, input logic [15:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL R%0d: actual %h expected %h", req, act, expv);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int seen;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12 reset state
        check(12, {wake_n, uart_clk_en, irq_out, 13'd0}, {3'b111, 13'd0});
        check(12, csr_rdata, 16'h0000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            modem_in   = VEC[i].mdm;
            sin        = VEC[i].sn;
            gp_pin     = VEC[i].gp;
            acc_is_cfg = VEC[i].cfg;
            repeat (4) @(posedge clk);
            @(negedge clk);
            csr_wr_en = VEC[i].wr;
            csr_wdata = VEC[i].wd;
            cfg_wr_en = VEC[i].cw;
            cfg_wdata = VEC[i].cwd;
            @(posedge clk);
            @(negedge clk);
            csr_wr_en = 1'b0;
            cfg_wr_en = 1'b0;
            repeat (4) @(posedge clk);
            @(negedge clk);
            check(int'(VEC[i].req), {9'd0, observe()}, {9'd0, VEC[i].exp});
        end

        // R12 reset mid-run clears configuration and state
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(12, {csr_rdata[15:1], uart_clk_en}, {15'd0, 1'b1});
        rst_n = 1'b1;
        modem_in = 4'h0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        csr_wr_en = 1'b1;
        csr_wdata = 16'h0102;
        @(posedge clk);
        @(negedge clk);
        csr_wr_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8 cts previously masked: after reset the mask is clear
        modem_in = 4'h1;
        seen = 0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (seen == 0 && !wake_n) begin
                seen = 1;
                // R6 wake_n low while status not yet latched
                check(6, {15'd0, csr_rdata[15]}, 16'd0);
            end
        end
        check(8, {15'd0, seen[0]}, 16'd1);
        check(4, {15'd0, csr_rdata[15]}, 16'd1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule